// File: doc/BRIEF.md
# Packet Page Allocator with Page Queues

This block hands out a small pool of fixed-size buffer pages inside an Ethernet controller and tracks, by page number, what happens to each page. A host writes command bytes to allocate a page for a frame it wants to send, to give pages back, to hand a page to the transmitter, to take finished receive pages off the receive queue, and to clear the allocator or the transmit side. The receive path asks for a page through a request pulse. The transmit path reports through an event pulse that the oldest queued page has gone out on the wire.

Four pages of 2048 bytes are managed by default. A busy bitmask records which pages are in use. Three page-number queues, each as deep as the page count, hold pages waiting to be sent, sent pages waiting for the host to collect them, and received pages waiting for the host to read them. An 8-bit interrupt status register and an 8-bit mask drive one level-sensitive interrupt line. If a transmit allocation finds no free page, the failure is remembered. The allocation is then retried automatically the next time any page is freed.

Top module: `pkt_page_mgr`

## Requirements
- R1: A transmit allocation takes the lowest-numbered free page. It marks that page busy, reports its number on `alloc_result` and sets status bit 3.
- R2: A transmit allocation first sets `alloc_result` to 0x80 and clears status bit 3. If no page is free, the result stays 0x80. Any later page release made while the result is still 0x80 retries the allocation in that same cycle.
- R3: The command is bits 7:5 of `cmd_byte`, and bits 4:0 are ignored. The codes are: 0 no-op; 1 transmit allocate; 2 allocator reset; 3 pop receive queue; 4 pop receive queue and free its head page; 5 free the page in the page-number register; 6 append that page to the transmit queue; 7 empty the transmit queue and the completion queue.
- R4: Allocator reset marks every page free, empties all three queues and sets `alloc_result` to 0x00. It leaves the interrupt status and mask as they are.
- R5: `rx_head` and `done_head` show the head page number of their queue, or 0x80 when that queue is empty.
- R6: A receive pop moves the remaining entries forward. Status bit 0 becomes 1 if entries remain and 0 if the queue is left empty. Code 4 also frees the page that was at the head.
- R7: A `tx_sent` pulse removes the transmit queue head. With `auto_release` high, that page is freed. With `auto_release` low, its number joins the completion queue if there is space. The pulse is ignored when the transmit queue is empty.
- R8: Status bit 2 is set every cycle the transmit queue ends empty. Status bit 1 is set every cycle the completion queue ends non-empty.
- R9: An acknowledge write clears the status bits selected by `ack_byte` AND 0xD6. A 1 in bit 1 also removes one completion queue entry. `irq` is high exactly when status AND mask is non-zero.
- R10: After reset the status is 0x04, the mask is 0x00, all pages are free, `alloc_result` is 0x00 and both heads read 0x80.
- R11: Appending to a transmit queue that already holds as many entries as there are pages has no effect.
- R12: A receive request takes the lowest free page and appends it to the receive queue. It also sets status bit 0. On the next cycle it reports `rx_resp` with the page number. If no page is free, it reports `rx_fail` instead and changes nothing.
- R13: Within one cycle, effects apply in this order: the command, then acknowledge and mask writes, then `tx_sent`, then the receive request. Each stage sees the pages freed or taken by the stages before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_release | input | 1 | Free sent pages instead of queueing them for the host |
| cmd_we | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte, code in bits 7:5 |
| pnum_we | input | 1 | Page-number register write strobe |
| pnum_wdata | input | PW | New page-number register value |
| ack_we | input | 1 | Interrupt acknowledge strobe |
| ack_byte | input | 8 | Status bits to acknowledge |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_byte | input | 8 | New interrupt mask |
| tx_sent | input | 1 | Transmit queue head has been sent |
| rx_req | input | 1 | Receive path asks for a page |
| rx_resp | output | 1 | Response to the previous cycle's receive request |
| rx_fail | output | 1 | That request found no free page |
| rx_page | output | PW | Page granted to that request |
| alloc_result | output | 8 | Transmit allocation result, 0x80 on failure |
| rx_head | output | 8 | Receive queue head, 0x80 if empty |
| done_head | output | 8 | Completion queue head, 0x80 if empty |
| page_busy | output | NUM_PAGES | Busy bitmask, bit n for page n |
| int_status | output | 8 | Interrupt status |
| int_mask | output | 8 | Interrupt mask |
| irq | output | 1 | Level interrupt |

## Verification
The receive page request and a page-freeing command share the pool within a single cycle. The bench fills all four pages, then issues a "free page 2" command in the same cycle as a receive request. The request must be granted page 2, with the busy mask staying full. In a second run the bench first makes a transmit allocation fail. It then repeats the same pair, so the automatic retry claims the freed page before the receive request, which must report a failure while `alloc_result` turns to 2.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  typedef enum logic [2:0] {
    OP_NOP         = 3'd0,
    OP_TX_ALLOC    = 3'd1,
    OP_RESET       = 3'd2,
    OP_RX_POP      = 3'd3,
    OP_RX_POP_FREE = 3'd4,
    OP_FREE        = 3'd5,
    OP_TX_QUEUE    = 3'd6,
    OP_TX_CLEAR    = 3'd7
  } ppm_op_e;

  localparam logic [7:0] NO_PAGE  = 8'h80;
  localparam logic [7:0] ACK_MASK = 8'hD6;
  localparam int IRQ_RX      = 0;
  localparam int IRQ_TXDONE  = 1;
  localparam int IRQ_TXEMPTY = 2;
  localparam int IRQ_ALLOC   = 3;
  localparam logic [7:0] ST_RESET = 8'h04;
endpackage

// File: rtl/ppm_find_free.sv
module ppm_find_free #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic [N-1:0]  busy,
  output logic          found,
  output logic [PW-1:0] idx
);
  // scan from the top so the lowest free page is the last one written
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = PW'(i);
      end
    end
  end
endmodule

// File: rtl/ppm_pageq.sv
module ppm_pageq #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  pdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic          empty
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [W-1:0]  mem_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d, base;
  logic          pop_eff, push_eff;

  always_comb begin
    pop_eff  = pop && (cnt_q != '0) && !clr;
    base     = clr ? '0 : (cnt_q - CW'(pop_eff));
    push_eff = push && (base < CW'(DEPTH));
    for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
    if (pop_eff) begin
      for (int i = 0; i < DEPTH - 1; i++) mem_d[i] = mem_q[i + 1];
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (push_eff && (base == CW'(i))) mem_d[i] = pdata;
    end
    cnt_d = base + CW'(push_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // page-number storage carries no reset; entries are read only below count
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
  end

  assign head      = mem_q[0];
  assign count     = cnt_q;
  assign count_nxt = cnt_d;
  assign empty     = (cnt_q == '0);

  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_full_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH) && push && !pop && !clr) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr
  import ppm_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  localparam int PW = $clog2(NUM_PAGES),
  localparam int CW = $clog2(NUM_PAGES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 auto_release,
  input  logic                 cmd_we,
  input  logic [7:0]           cmd_byte,
  input  logic                 pnum_we,
  input  logic [PW-1:0]        pnum_wdata,
  input  logic                 ack_we,
  input  logic [7:0]           ack_byte,
  input  logic                 mask_we,
  input  logic [7:0]           mask_byte,
  input  logic                 tx_sent,
  input  logic                 rx_req,
  output logic                 rx_resp,
  output logic                 rx_fail,
  output logic [PW-1:0]        rx_page,
  output logic [7:0]           alloc_result,
  output logic [7:0]           rx_head,
  output logic [7:0]           done_head,
  output logic [NUM_PAGES-1:0] page_busy,
  output logic [7:0]           int_status,
  output logic [7:0]           int_mask,
  output logic                 irq
);
  // state
  logic [NUM_PAGES-1:0] busy_q, busy_d;
  logic [7:0]           alloc_q, alloc_d, st_q, st_d, mask_q, mask_d;
  logic [PW-1:0]        pnum_q, pnum_d, rxp_q, rxp_d;
  logic                 rxr_q, rxf_q, rxf_d;

  // queue connections
  logic          rxq_clr, rxq_push, rxq_pop, rxq_empty;
  logic [PW-1:0] rxq_head;
  logic [CW-1:0] rxq_cnt, rxq_nxt_unused;
  logic          txq_clr, txq_push, txq_pop, txq_empty;
  logic [PW-1:0] txq_head;
  logic [CW-1:0] txq_cnt, txq_cnt_nxt;
  logic          dnq_clr, dnq_push, dnq_pop, dnq_empty;
  logic [PW-1:0] dnq_head;
  logic [CW-1:0] dnq_cnt, dnq_cnt_nxt;

  ppm_op_e op;
  logic    unused_low;
  assign op         = ppm_op_e'(cmd_byte[7:5]);
  assign unused_low = ^cmd_byte[4:0];

  // ---------------- stage 1: host command ----------------
  logic [NUM_PAGES-1:0] map_a, map1;
  logic [7:0]           res1, res1b, st1, st1b;
  logic                 try1, f1_found;
  logic [PW-1:0]        f1_idx;

  always_comb begin
    map_a   = busy_q;
    res1    = alloc_q;
    st1     = st_q;
    try1    = 1'b0;
    rxq_pop = 1'b0;
    rxq_clr = 1'b0;
    txq_clr = 1'b0;
    txq_push = 1'b0;
    dnq_clr = 1'b0;
    if (cmd_we) begin
      unique case (op)
        OP_NOP: ;
        OP_TX_ALLOC: begin
          res1           = NO_PAGE;
          st1[IRQ_ALLOC] = 1'b0;
          try1           = 1'b1;
        end
        OP_RESET: begin
          map_a   = '0;
          res1    = 8'h00;
          rxq_clr = 1'b1;
          txq_clr = 1'b1;
          dnq_clr = 1'b1;
        end
        OP_RX_POP: begin
          rxq_pop     = 1'b1;
          st1[IRQ_RX] = (rxq_cnt > CW'(1));
        end
        OP_RX_POP_FREE: begin
          if (!rxq_empty) begin
            map_a[rxq_head] = 1'b0;
            try1            = (alloc_q == NO_PAGE);
          end
          rxq_pop     = 1'b1;
          st1[IRQ_RX] = (rxq_cnt > CW'(1));
        end
        OP_FREE: begin
          map_a[pnum_q] = 1'b0;
          try1          = (alloc_q == NO_PAGE);
        end
        OP_TX_QUEUE: txq_push = 1'b1;
        OP_TX_CLEAR: begin
          txq_clr = 1'b1;
          dnq_clr = 1'b1;
        end
        default: ;
      endcase
    end
  end

  ppm_find_free #(.N(NUM_PAGES), .PW(PW)) u_find_cmd (
    .busy(map_a), .found(f1_found), .idx(f1_idx));

  always_comb begin
    map1  = map_a;
    res1b = res1;
    st1b  = st1;
    if (try1 && f1_found) begin
      map1[f1_idx]    = 1'b1;
      res1b           = {{(8 - PW){1'b0}}, f1_idx};
      st1b[IRQ_ALLOC] = 1'b1;
    end
  end

  // ---------------- stage 2: acknowledge and transmit event ----------------
  logic [NUM_PAGES-1:0] map_b, map2;
  logic [7:0]           st2, res2, st2b;
  logic                 send_ok, try2, f2_found;
  logic [PW-1:0]        f2_idx;

  always_comb begin
    st2      = st1b;
    dnq_pop  = 1'b0;
    if (ack_we) begin
      st2     = st1b & ~(ack_byte & ACK_MASK);
      dnq_pop = ack_byte[IRQ_TXDONE];
    end
    send_ok  = tx_sent && !txq_empty && !txq_clr;
    txq_pop  = send_ok;
    map_b    = map1;
    try2     = 1'b0;
    dnq_push = 1'b0;
    if (send_ok) begin
      if (auto_release) begin
        map_b[txq_head] = 1'b0;
        try2            = (res1b == NO_PAGE);
      end else begin
        dnq_push = 1'b1;
      end
    end
  end

  ppm_find_free #(.N(NUM_PAGES), .PW(PW)) u_find_sent (
    .busy(map_b), .found(f2_found), .idx(f2_idx));

  always_comb begin
    map2 = map_b;
    res2 = res1b;
    st2b = st2;
    if (try2 && f2_found) begin
      map2[f2_idx]    = 1'b1;
      res2            = {{(8 - PW){1'b0}}, f2_idx};
      st2b[IRQ_ALLOC] = 1'b1;
    end
  end

  // ---------------- stage 3: receive page request ----------------
  logic          f3_found, rx_ok;
  logic [PW-1:0] f3_idx;

  ppm_find_free #(.N(NUM_PAGES), .PW(PW)) u_find_rx (
    .busy(map2), .found(f3_found), .idx(f3_idx));

  always_comb begin
    rx_ok    = rx_req && f3_found;
    rxq_push = rx_ok;
    rxf_d    = rx_req && !f3_found;
    rxp_d    = rx_ok ? f3_idx : rxp_q;
    busy_d   = map2 | (rx_ok ? (NUM_PAGES'(1) << f3_idx) : '0);
    alloc_d  = res2;
    mask_d   = mask_we ? mask_byte : mask_q;
    pnum_d   = pnum_we ? pnum_wdata : pnum_q;
    st_d     = st2b | {5'b0, (txq_cnt_nxt == '0), (dnq_cnt_nxt != '0), rx_ok};
  end

  // ---------------- queues ----------------
  ppm_pageq #(.DEPTH(NUM_PAGES), .W(PW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rxq_clr), .push(rxq_push), .pdata(f3_idx),
    .pop(rxq_pop), .head(rxq_head), .count(rxq_cnt), .count_nxt(rxq_nxt_unused),
    .empty(rxq_empty));

  ppm_pageq #(.DEPTH(NUM_PAGES), .W(PW)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(txq_clr), .push(txq_push), .pdata(pnum_q),
    .pop(txq_pop), .head(txq_head), .count(txq_cnt), .count_nxt(txq_cnt_nxt),
    .empty(txq_empty));

  ppm_pageq #(.DEPTH(NUM_PAGES), .W(PW)) u_dnq (
    .clk(clk), .rst_n(rst_n), .clr(dnq_clr), .push(dnq_push), .pdata(txq_head),
    .pop(dnq_pop), .head(dnq_head), .count(dnq_cnt), .count_nxt(dnq_cnt_nxt),
    .empty(dnq_empty));

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= '0;
      alloc_q <= 8'h00;
      st_q    <= ST_RESET;
      mask_q  <= 8'h00;
      pnum_q  <= '0;
      rxr_q   <= 1'b0;
      rxf_q   <= 1'b0;
      rxp_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      alloc_q <= alloc_d;
      st_q    <= st_d;
      mask_q  <= mask_d;
      pnum_q  <= pnum_d;
      rxr_q   <= rx_req;
      rxf_q   <= rxf_d;
      rxp_q   <= rxp_d;
    end
  end

  assign rx_resp      = rxr_q;
  assign rx_fail      = rxf_q;
  assign rx_page      = rxp_q;
  assign alloc_result = alloc_q;
  assign rx_head      = rxq_empty ? NO_PAGE : {{(8 - PW){1'b0}}, rxq_head};
  assign done_head    = dnq_empty ? NO_PAGE : {{(8 - PW){1'b0}}, dnq_head};
  assign page_busy    = busy_q;
  assign int_status   = st_q;
  assign int_mask     = mask_q;
  assign irq          = |(st_q & mask_q);

  // ---------------- assertions ----------------
  p_txempty_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    txq_empty |-> st_q[IRQ_TXEMPTY]);
  p_txdone_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dnq_empty |-> st_q[IRQ_TXDONE]);
  p_alloc_fail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && op == OP_TX_ALLOC && (&busy_q) && !(tx_sent && auto_release))
      |=> (alloc_q == NO_PAGE && !st_q[IRQ_ALLOC]));
  p_reset_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && op == OP_RESET) |=> (alloc_q == 8'h00 && txq_empty && dnq_empty));
  p_rx_fail_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_q |-> (&busy_q));
endmodule

// File: tb/sim_pkt_page_mgr.sv
`timescale 1ns/1ps
module sim_pkt_page_mgr;
  localparam real CLK_NS = 8.0;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       auto_release, cmd_we, pnum_we, ack_we, mask_we, tx_sent, rx_req;
  logic [7:0] cmd_byte, ack_byte, mask_byte;
  logic [1:0] pnum_wdata;
  logic       rx_resp, rx_fail, irq;
  logic [1:0] rx_page;
  logic [7:0] alloc_result, rx_head, done_head, int_status, int_mask;
  logic [3:0] page_busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_NS / 2.0) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pkt_page_mgr u0 (
    .clk(clk), .rst_n(rst_n), .auto_release(auto_release),
    .cmd_we(cmd_we), .cmd_byte(cmd_byte), .pnum_we(pnum_we), .pnum_wdata(pnum_wdata),
    .ack_we(ack_we), .ack_byte(ack_byte), .mask_we(mask_we), .mask_byte(mask_byte),
    .tx_sent(tx_sent), .rx_req(rx_req), .rx_resp(rx_resp), .rx_fail(rx_fail),
    .rx_page(rx_page), .alloc_result(alloc_result), .rx_head(rx_head),
    .done_head(done_head), .page_busy(page_busy), .int_status(int_status),
    .int_mask(int_mask), .irq(irq));

  typedef struct {
    int         due;
    string      tag;
    logic [7:0] al, rh, dh, st;
    logic [3:0] bz;
    logic       iq;
    logic [1:0] rr;
    logic [1:0] rp;
  } exp_t;

  exp_t sb[$];

  task automatic chk(input string tag, input string f, input logic [7:0] a, input logic [7:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, f, a, e);
    end
  endtask

  // monitor: compares every expectation once it falls due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, "alloc_result", alloc_result, e.al);
      chk(e.tag, "rx_head", rx_head, e.rh);
      chk(e.tag, "done_head", done_head, e.dh);
      chk(e.tag, "int_status", int_status, e.st);
      chk(e.tag, "page_busy", {4'b0, page_busy}, {4'b0, e.bz});
      chk(e.tag, "irq", {7'b0, irq}, {7'b0, e.iq});
      chk(e.tag, "rx_resp/fail", {6'b0, rx_resp, rx_fail}, {6'b0, e.rr});
      if (e.rr == 2'b10) chk(e.tag, "rx_page", {6'b0, rx_page}, {6'b0, e.rp});
    end
  end

  // driver: inputs already set; record expectation for after the next edge
  task automatic go(input string tag, input logic [7:0] al, rh, dh, st,
                    input logic [3:0] bz, input logic iq,
                    input logic [1:0] rr = 2'b00, input logic [1:0] rp = 2'b00);
    exp_t e;
    e.due = cyc + 1; e.tag = tag; e.al = al; e.rh = rh; e.dh = dh; e.st = st;
    e.bz = bz; e.iq = iq; e.rr = rr; e.rp = rp;
    sb.push_back(e);
    @(posedge clk);
    @(negedge clk);
    cmd_we = 0; pnum_we = 0; ack_we = 0; mask_we = 0; tx_sent = 0; rx_req = 0;
  endtask

  task automatic cmd(input logic [7:0] b);  cmd_we = 1; cmd_byte = b; endtask
  task automatic pn(input logic [1:0] p);   pnum_we = 1; pnum_wdata = p; endtask
  task automatic ack(input logic [7:0] b);  ack_we = 1; ack_byte = b; endtask

  initial begin
    #(CLK_NS * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; auto_release = 0; cmd_we = 0; pnum_we = 0; ack_we = 0; mask_we = 0;
    tx_sent = 0; rx_req = 0; cmd_byte = 0; ack_byte = 0; mask_byte = 0; pnum_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    go("R10 reset state, R5 empty heads", 8'h00, 8'h80, 8'h80, 8'h04, 4'h0, 0);
    mask_we = 1; mask_byte = 8'hFF;
    go("R9 mask enables irq", 8'h00, 8'h80, 8'h80, 8'h04, 4'h0, 1);
    cmd(8'h20);
    go("R1 first alloc page0", 8'h00, 8'h80, 8'h80, 8'h0C, 4'h1, 1);
    cmd(8'h3F);
    go("R3 low bits ignored, R1 page1", 8'h01, 8'h80, 8'h80, 8'h0C, 4'h3, 1);
    rx_req = 1;
    go("R12 rx gets page2", 8'h01, 8'h02, 8'h80, 8'h0D, 4'h7, 1, 2'b10, 2'd2);
    rx_req = 1;
    go("R12 rx gets page3", 8'h01, 8'h02, 8'h80, 8'h0D, 4'hF, 1, 2'b10, 2'd3);
    cmd(8'h20);
    go("R2 alloc fails when full", 8'h80, 8'h02, 8'h80, 8'h05, 4'hF, 1);
    rx_req = 1;
    go("R12 rx fails when full", 8'h80, 8'h02, 8'h80, 8'h05, 4'hF, 1, 2'b11);
    pn(2'd1); cmd(8'h1F);
    go("R3 no-op changes nothing", 8'h80, 8'h02, 8'h80, 8'h05, 4'hF, 1);
    cmd(8'hA0);
    go("R2 release retries alloc", 8'h01, 8'h02, 8'h80, 8'h0D, 4'hF, 1);
    cmd(8'h60);
    go("R6 pop keeps bit0 while entries remain", 8'h01, 8'h03, 8'h80, 8'h0D, 4'hF, 1);
    cmd(8'h80);
    go("R6 pop-free empties queue and frees page3", 8'h01, 8'h80, 8'h80, 8'h0C, 4'h7, 1);
    cmd(8'hC0);
    go("R7 queue page1", 8'h01, 8'h80, 8'h80, 8'h0C, 4'h7, 1);
    ack(8'h04);
    go("R8 bit2 clears while tx queue busy", 8'h01, 8'h80, 8'h80, 8'h08, 4'h7, 1);
    tx_sent = 1;
    go("R7 sent page enters completion queue", 8'h01, 8'h80, 8'h01, 8'h0E, 4'h7, 1);
    ack(8'h02);
    go("R9 ack bit1 pops completion", 8'h01, 8'h80, 8'h80, 8'h0C, 4'h7, 1);
    ack(8'hFF);
    go("R9 ack leaves bit3", 8'h01, 8'h80, 8'h80, 8'h0C, 4'h7, 1);
    mask_we = 1; mask_byte = 8'h01;
    go("R9 irq low when masked out", 8'h01, 8'h80, 8'h80, 8'h0C, 4'h7, 0);

    // R11: fill the transmit queue and try one more
    pn(2'd0);            go("R11 setup", 8'h01, 8'h80, 8'h80, 8'h0C, 4'h7, 0);
    cmd(8'hC0); pn(2'd1); go("R11 q0", 8'h01, 8'h80, 8'h80, 8'h0C, 4'h7, 0);
    cmd(8'hC0); pn(2'd2); go("R11 q1", 8'h01, 8'h80, 8'h80, 8'h0C, 4'h7, 0);
    cmd(8'hC0); pn(2'd0); go("R11 q2", 8'h01, 8'h80, 8'h80, 8'h0C, 4'h7, 0);
    cmd(8'hC0); pn(2'd1); go("R11 q3", 8'h01, 8'h80, 8'h80, 8'h0C, 4'h7, 0);
    cmd(8'hC0);           go("R11 q4 ignored", 8'h01, 8'h80, 8'h80, 8'h0C, 4'h7, 0);
    ack(8'h04);           go("R11 clear bit2", 8'h01, 8'h80, 8'h80, 8'h08, 4'h7, 0);
    tx_sent = 1; go("R7 send 1", 8'h01, 8'h80, 8'h00, 8'h0A, 4'h7, 0);
    tx_sent = 1; go("R7 send 2", 8'h01, 8'h80, 8'h00, 8'h0A, 4'h7, 0);
    tx_sent = 1; go("R7 send 3", 8'h01, 8'h80, 8'h00, 8'h0A, 4'h7, 0);
    tx_sent = 1; go("R11 fourth send empties queue", 8'h01, 8'h80, 8'h00, 8'h0E, 4'h7, 0);
    tx_sent = 1; go("R7 send on empty ignored", 8'h01, 8'h80, 8'h00, 8'h0E, 4'h7, 0);
    ack(8'h02); go("R9 pop done 1", 8'h01, 8'h80, 8'h01, 8'h0E, 4'h7, 0);
    ack(8'h02); go("R9 pop done 2", 8'h01, 8'h80, 8'h02, 8'h0E, 4'h7, 0);
    ack(8'h02); go("R9 pop done 3", 8'h01, 8'h80, 8'h00, 8'h0E, 4'h7, 0);
    ack(8'h02); go("R11 only four completions", 8'h01, 8'h80, 8'h80, 8'h0C, 4'h7, 0);

    // R7 auto release
    pn(2'd2);    go("R7 setup", 8'h01, 8'h80, 8'h80, 8'h0C, 4'h7, 0);
    cmd(8'hC0);  go("R7 queue page2", 8'h01, 8'h80, 8'h80, 8'h0C, 4'h7, 0);
    auto_release = 1; tx_sent = 1;
    go("R7 auto release frees page2", 8'h01, 8'h80, 8'h80, 8'h0C, 4'h3, 0);

    // R13 same-cycle ordering
    cmd(8'h20);  go("R13 setup alloc page2", 8'h02, 8'h80, 8'h80, 8'h0C, 4'h7, 0);
    rx_req = 1;  go("R13 setup rx page3", 8'h02, 8'h03, 8'h80, 8'h0D, 4'hF, 1, 2'b10, 2'd3);
    cmd(8'hA0); rx_req = 1;
    go("R13 release then rx takes page2", 8'h02, 8'h03, 8'h80, 8'h0D, 4'hF, 1, 2'b10, 2'd2);
    cmd(8'h20);  go("R13 alloc fails", 8'h80, 8'h03, 8'h80, 8'h05, 4'hF, 1);
    cmd(8'hA0); rx_req = 1;
    go("R13 retry beats rx request", 8'h02, 8'h03, 8'h80, 8'h0D, 4'hF, 1, 2'b11);

    cmd(8'h40);
    go("R4 allocator reset", 8'h00, 8'h80, 8'h80, 8'h0D, 4'h0, 1);

    auto_release = 0;
    cmd(8'hC0);  go("R3 queue after reset", 8'h00, 8'h80, 8'h80, 8'h0D, 4'h0, 1);
    tx_sent = 1; go("R7 completion page2", 8'h00, 8'h80, 8'h02, 8'h0F, 4'h0, 1);
    cmd(8'hC0);  go("R3 queue again", 8'h00, 8'h80, 8'h02, 8'h0F, 4'h0, 1);
    ack(8'h04);  go("R8 clear bit2", 8'h00, 8'h80, 8'h02, 8'h0B, 4'h0, 1);
    cmd(8'hE0);  go("R3 code7 clears tx and completion", 8'h00, 8'h80, 8'h80, 8'h0F, 4'h0, 1);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule